// File: doc/BRIEF.md
# Grouped Programmable Pulse Output Generator

The block drives a 16-bit parallel pulse bus split into four 4-bit groups. Each group holds a current output register. When the timer compare strobe that the group has selected fires, the group reloads that register from a next-data nibble. Software or a DMA engine fills the next-data register ahead of time. The selected strobe also raises a per-group transfer request, so a DMA engine can refill next-data on each event and stream a waveform with no processor involvement.

Each group chooses one of four compare channels. Each group can also insert a non-overlap gap: bits that fall are released on the channel's first compare strobe, and bits that rise wait for its second compare strobe. Per-bit output enables and per-group inversion shape the pins. The block leaves reset in a stopped state. In that state it ignores configuration writes and compare strobes until software clears the stop bit.

Top module: `ppg_top`

## Requirements
- R1: After reset, `pulse_out` and `xfer_req` are all zero. The stop bit reads 1, and the next-data, enable, select, non-overlap, invert and output registers read 0.
- R2: While the stop bit is 1, writes to any address other than the stop address are ignored. Compare strobes change neither the output register nor the pins, and no `xfer_req` is raised. Writing the stop address (5) is always accepted, and its bit 0 is the stop bit.
- R3: The register port decodes 3-bit addresses as follows. Address 0 is next-data [15:0]. Address 1 is output enable [15:0]. Address 2 is trigger select [7:0], two bits per group with group g at bits [2g+1:2g]. Address 3 is non-overlap, bit g for group g. Address 4 is invert, bit g for group g. Address 5 is stop [0]. Address 6 is the read-only output register [15:0]. `bus_rdata` shows the addressed register combinationally, zero-extended. Other addresses read 0.
- R4: In normal mode, a pulse on `cm_a[s]` copies the next-data nibble into the output register of every group whose select field equals s. This happens at the clock edge that samples the strobe. Group g owns bits [4g+3:4g].
- R5: A group ignores every strobe on a channel other than its selected one.
- R6: A bit whose output enable is 0 drives 0 on `pulse_out` and keeps its output-register value through transfers.
- R7: For an enabled bit of a group with invert set, `pulse_out` shows the complement of the output-register bit.
- R8: In non-overlap mode, `cm_a[s]` clears the enabled bits that are 1 in the output register and 0 in next-data. `cm_b[s]` sets the enabled bits that are 0 in the output register and 1 in next-data. When both strobes arrive together, both updates apply.
- R9: When not stopped, a pulse on the selected `cm_a` channel makes the group's `xfer_req` bit high for exactly the one following cycle.
- R10: When a next-data write and a selected strobe arrive in the same cycle, the group transfers the next-data value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| cm_a | input | 4 | First compare strobe for each timer channel |
| cm_b | input | 4 | Second compare strobe for each timer channel |
| pulse_out | output | 16 | Pulse output pins |
| xfer_req | output | 4 | Per-group transfer request pulse |

## Verification
The assertions assume that the compare strobes are single-cycle, synchronous pulses. They also assume that the output register cannot change in a cycle with no strobe, and that a rising bit in non-overlap mode is always tied to a second-strobe pulse in the previous cycle. The stimulus raises each strobe for one clock only and always returns it to zero before the next pulse. It drives register writes apart from strobes, except in the collision test. The bench sweeps every select combination, every old and new nibble pair in non-overlap mode, and rotating enable and invert masks. It compares each result against a cycle model written from the requirements.

// File: rtl/ppg_pkg.sv
// Package: shared sizes and register address codes for the grouped pulse
// generator. Assumes the select field is wide enough to index every source.
package ppg_pkg;
    localparam int GRP_W_D  = 4;
    localparam int N_GRP_D  = 4;
    localparam int N_SRC_D  = 4;
    localparam int ADDR_W   = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_NEXT = 3'd0,
        A_OE   = 3'd1,
        A_TSEL = 3'd2,
        A_NOVL = 3'd3,
        A_INV  = 3'd4,
        A_STOP = 3'd5,
        A_OUT  = 3'd6
    } reg_addr_e;
endpackage

// File: rtl/ppg_regs.sv
// Module: configuration register file. Holds next-data, enables, select,
// non-overlap, invert and stop bits. Writes other than to stop are dropped
// while stopped. Read data is combinational. Assumes DATA_W covers every field.
module ppg_regs
    import ppg_pkg::*;
#(
    parameter int GRP_W = GRP_W_D,
    parameter int N_GRP = N_GRP_D,
    parameter int SEL_W = 2,
    localparam int DATA_W = GRP_W * N_GRP,
    localparam int TSEL_W = SEL_W * N_GRP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] out_q,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] next_q,
    output logic [DATA_W-1:0] oe_q,
    output logic [TSEL_W-1:0] tsel_q,
    output logic [N_GRP-1:0]  novl_q,
    output logic [N_GRP-1:0]  inv_q,
    output logic              stop_q
);
    logic wdata_unused;
    assign wdata_unused = ^bus_wdata;

    // Register update: stop always writable, others only when running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_q <= '0;
            oe_q   <= '0;
            tsel_q <= '0;
            novl_q <= '0;
            inv_q  <= '0;
            stop_q <= 1'b1;
        end else if (bus_wr) begin
            if (bus_addr == A_STOP) begin
                stop_q <= bus_wdata[0];
            end else if (!stop_q) begin
                case (bus_addr)
                    A_NEXT:  next_q <= bus_wdata;
                    A_OE:    oe_q   <= bus_wdata;
                    A_TSEL:  tsel_q <= bus_wdata[TSEL_W-1:0];
                    A_NOVL:  novl_q <= bus_wdata[N_GRP-1:0];
                    A_INV:   inv_q  <= bus_wdata[N_GRP-1:0];
                    default: ;
                endcase
            end
        end
    end

    // Read mux: zero-extended view of the addressed register.
    always_comb begin
        case (bus_addr)
            A_NEXT:  bus_rdata = next_q;
            A_OE:    bus_rdata = oe_q;
            A_TSEL:  bus_rdata = DATA_W'(tsel_q);
            A_NOVL:  bus_rdata = DATA_W'(novl_q);
            A_INV:   bus_rdata = DATA_W'(inv_q);
            A_STOP:  bus_rdata = DATA_W'(stop_q);
            A_OUT:   bus_rdata = out_q;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ppg_group.sv
// Module: one output group. Picks its compare channel and updates its output
// register in normal or non-overlap fashion. Raises a one-cycle request.
// Assumes strobes are single-cycle synchronous pulses and sel < N_SRC.
module ppg_group #(
    parameter int GRP_W = 4,
    parameter int N_SRC = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    input  logic             novl,
    input  logic             inv,
    input  logic [GRP_W-1:0] oe,
    input  logic [GRP_W-1:0] nd,
    input  logic [N_SRC-1:0] cm_a,
    input  logic [N_SRC-1:0] cm_b,
    output logic [GRP_W-1:0] out_q,
    output logic [GRP_W-1:0] pin,
    output logic             req
);
    logic             fa, fb;
    logic [GRP_W-1:0] fall, rise, nxt;

    assign fa = run & cm_a[sel];
    assign fb = run & cm_b[sel];

    // Next-state: split edges in non-overlap mode, whole nibble otherwise.
    always_comb begin
        fall = out_q & ~nd & oe & {GRP_W{fa}};
        rise = ~out_q & nd & oe & {GRP_W{fb}};
        if (novl)
            nxt = (out_q & ~fall) | rise;
        else if (fa)
            nxt = (oe & nd) | (~oe & out_q);
        else
            nxt = out_q;
    end

    // State: output register and request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
            req   <= 1'b0;
        end else begin
            out_q <= nxt;
            req   <= fa;
        end
    end

    assign pin = oe & (out_q ^ {GRP_W{inv}});
endmodule

// File: rtl/ppg_top.sv
// Module: grouped programmable pulse generator top. Joins the register file
// to one group slice per output nibble. Assumes one compare channel per timer.
module ppg_top
    import ppg_pkg::*;
#(
    parameter int GRP_W = GRP_W_D,
    parameter int N_GRP = N_GRP_D,
    parameter int N_SRC = N_SRC_D,
    localparam int SEL_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int DATA_W = GRP_W * N_GRP,
    localparam int TSEL_W = SEL_W * N_GRP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_SRC-1:0]  cm_a,
    input  logic [N_SRC-1:0]  cm_b,
    output logic [DATA_W-1:0] pulse_out,
    output logic [N_GRP-1:0]  xfer_req
);
    logic [DATA_W-1:0] next_q, oe_q, out_q;
    logic [TSEL_W-1:0] tsel_q;
    logic [N_GRP-1:0]  novl_q, inv_q;
    logic              stop_q;

    ppg_regs #(.GRP_W(GRP_W), .N_GRP(N_GRP), .SEL_W(SEL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .out_q     (out_q),
        .bus_rdata (bus_rdata),
        .next_q    (next_q),
        .oe_q      (oe_q),
        .tsel_q    (tsel_q),
        .novl_q    (novl_q),
        .inv_q     (inv_q),
        .stop_q    (stop_q)
    );

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        ppg_group #(.GRP_W(GRP_W), .N_SRC(N_SRC), .SEL_W(SEL_W)) u_grp (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (~stop_q),
            .sel   (tsel_q[g*SEL_W +: SEL_W]),
            .novl  (novl_q[g]),
            .inv   (inv_q[g]),
            .oe    (oe_q[g*GRP_W +: GRP_W]),
            .nd    (next_q[g*GRP_W +: GRP_W]),
            .cm_a  (cm_a),
            .cm_b  (cm_b),
            .out_q (out_q[g*GRP_W +: GRP_W]),
            .pin   (pulse_out[g*GRP_W +: GRP_W]),
            .req   (xfer_req[g])
        );
    end
endmodule

// File: rtl/ppg_chk.sv
// Module: property checker bound to ppg_top. Assumes strobes are single-cycle
// pulses. It only observes ports and register state.
module ppg_chk #(
    parameter int GRP_W = 4,
    parameter int N_GRP = 4,
    parameter int N_SRC = 4,
    localparam int DATA_W = GRP_W * N_GRP
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SRC-1:0]  cm_a,
    input logic [N_SRC-1:0]  cm_b,
    input logic [N_GRP-1:0]  xfer_req,
    input logic              stop_q,
    input logic [DATA_W-1:0] oe_q,
    input logic [N_GRP-1:0]  novl_q,
    input logic [DATA_W-1:0] out_q
);
    AST_STOP_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        stop_q |=> (xfer_req == '0)); // R2
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        stop_q |=> $stable(out_q)); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_a == '0 && cm_b == '0) |=> $stable(out_q)); // R4
    AST_DIS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((out_q ^ $past(out_q)) & ~$past(oe_q)) == '0)); // R6
    AST_REQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req != '0) |-> $past(cm_a != '0)); // R9

    for (genvar g = 0; g < N_GRP; g++) begin : g_ast
        AST_NOVL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            (novl_q[g] && cm_b == '0) |=>
            ((out_q[g*GRP_W +: GRP_W] & ~$past(out_q[g*GRP_W +: GRP_W])) == '0)); // R8
        AST_NOVL_FALL: assert property (@(posedge clk) disable iff (!rst_n)
            (novl_q[g] && cm_a == '0) |=>
            ((~out_q[g*GRP_W +: GRP_W] & $past(out_q[g*GRP_W +: GRP_W])) == '0)); // R8
    end
endmodule

bind ppg_top ppg_chk #(.GRP_W(GRP_W), .N_GRP(N_GRP), .N_SRC(N_SRC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cm_a     (cm_a),
    .cm_b     (cm_b),
    .xfer_req (xfer_req),
    .stop_q   (stop_q),
    .oe_q     (oe_q),
    .novl_q   (novl_q),
    .out_q    (out_q)
);

// File: tb/tb_ppg_top.sv
// Bench: sweeps select codes, nibble transitions, enables and inversion,
// comparing ports against a cycle model built from the requirements.
module tb_ppg_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  cm_a = '0, cm_b = '0;
    logic [15:0] pulse_out;
    logic [3:0]  xfer_req;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [15:0] m_nd, m_oe, m_out;
    logic [7:0]  m_tsel;
    logic [3:0]  m_novl, m_inv, m_req;
    logic        m_stop;

    always #2 clk = ~clk;

    ppg_top dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cm_a(cm_a), .cm_b(cm_b),
        .pulse_out(pulse_out), .xfer_req(xfer_req)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] exp_pins();
        logic [15:0] r;
        for (int g = 0; g < 4; g++)
            r[g*4 +: 4] = m_oe[g*4 +: 4] & (m_out[g*4 +: 4] ^ {4{m_inv[g]}});
        return r;
    endfunction

    // Model of one clock edge with strobe masks a and b.
    task automatic model_step(input logic [3:0] a, input logic [3:0] b);
        for (int g = 0; g < 4; g++) begin
            int s = int'(m_tsel[g*2 +: 2]);
            logic fa = a[s] & ~m_stop;
            logic fb = b[s] & ~m_stop;
            m_req[g] = fa;
            for (int i = g*4; i < g*4 + 4; i++) begin
                if (m_oe[i]) begin
                    if (m_novl[g]) begin
                        if (fa && m_out[i] && !m_nd[i]) m_out[i] = 1'b0;
                        else if (fb && !m_out[i] && m_nd[i]) m_out[i] = 1'b1;
                    end else if (fa) begin
                        m_out[i] = m_nd[i];
                    end
                end
            end
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 3'd5) m_stop = d[0];
        else if (!m_stop) begin
            case (a)
                3'd0: m_nd = d;
                3'd1: m_oe = d;
                3'd2: m_tsel = d[7:0];
                3'd3: m_novl = d[3:0];
                3'd4: m_inv = d[3:0];
                default: ;
            endcase
        end
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    // Strobe for one cycle, optionally with a same-cycle next-data write.
    task automatic pulse(input logic [3:0] a, input logic [3:0] b,
                         input bit with_wr, input logic [15:0] d);
        @(negedge clk);
        cm_a = a; cm_b = b;
        if (with_wr) begin bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = d; end
        @(negedge clk);
        cm_a = '0; cm_b = '0; bus_wr = 1'b0;
        model_step(a, b);
        if (with_wr && !m_stop) m_nd = d;
        chk("R4 R6 R7 R8 pins", pulse_out, exp_pins());
        chk("R9 request", 16'(xfer_req), 16'(m_req));
        bus_addr = 3'd6;
        #1;
        chk("R5 R10 output register", bus_rdata, m_out);
        @(negedge clk);
        chk("R9 single cycle", 16'(xfer_req), 16'h0);
    endtask

    initial begin
        repeat (5000 * 30) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        m_nd = '0; m_oe = '0; m_out = '0; m_tsel = '0; m_novl = '0; m_inv = '0;
        m_req = '0; m_stop = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk("R1 pins", pulse_out, 16'h0);
        chk("R1 request", 16'(xfer_req), 16'h0);
        rd_chk(3'd5, 16'h1, "R1 stop");
        for (int a = 0; a < 5; a++) rd_chk(3'(a), 16'h0, "R1 register");
        rd_chk(3'd6, 16'h0, "R1 output register");

        // R2: stopped block ignores writes and strobes
        wr(3'd0, 16'hFFFF); wr(3'd1, 16'hFFFF);
        rd_chk(3'd0, 16'h0, "R2 next-data ignored");
        rd_chk(3'd1, 16'h0, "R2 enable ignored");
        pulse(4'hF, 4'hF, 0, 16'h0);

        // R3: register map readback
        wr(3'd5, 16'h0);
        rd_chk(3'd5, 16'h0, "R3 stop");
        wr(3'd0, 16'hA5C3); rd_chk(3'd0, 16'hA5C3, "R3 next-data");
        wr(3'd1, 16'h5AF0); rd_chk(3'd1, 16'h5AF0, "R3 enable");
        wr(3'd2, 16'hFFB4); rd_chk(3'd2, 16'h00B4, "R3 select");
        wr(3'd3, 16'hFFF9); rd_chk(3'd3, 16'h0009, "R3 non-overlap");
        wr(3'd4, 16'hFFF6); rd_chk(3'd4, 16'h0006, "R3 invert");
        rd_chk(3'd7, 16'h0, "R3 unmapped");

        // R4 R5 R6 R7 R9: sweep all select codes with rotating masks
        for (int it = 0; it < 256; it++) begin
            logic [15:0] h = 16'(it * 40503 + 12345);
            wr(3'd2, 16'(it));
            wr(3'd3, 16'((it >> 3) & 4'hF & (it * 5)));
            wr(3'd4, 16'(h[7:4]));
            wr(3'd1, (it % 4 == 3) ? (h ^ 16'h3C5A) : 16'hFFFF);
            for (int k = 0; k < 4; k++) begin
                wr(3'd0, 16'(h * (k + 3) ^ (k * 4919)));
                pulse(4'(1 << k), 4'h0, 0, 16'h0);
                pulse(4'h0, 4'(1 << k), 0, 16'h0);
                if (k == (it % 4)) pulse(4'(1 << k), 4'(1 << k), 0, 16'h0);
            end
        end

        // R8: every old/new nibble pair in non-overlap mode
        wr(3'd1, 16'hFFFF); wr(3'd2, 16'h0); wr(3'd3, 16'hF); wr(3'd4, 16'h0);
        for (int o = 0; o < 16; o++) begin
            for (int n = 0; n < 16; n++) begin
                wr(3'd0, {4{4'(o)}});
                pulse(4'h1, 4'h1, 0, 16'h0);
                wr(3'd0, {4{4'(n)}});
                pulse(4'h1, 4'h0, 0, 16'h0);
                chk("R8 after first strobe", m_out, {4{4'(o) & 4'(n)}});
                pulse(4'h0, 4'h1, 0, 16'h0);
            end
        end

        // R10: write colliding with the strobe transfers the old value
        wr(3'd3, 16'h0);
        wr(3'd0, 16'h1234);
        pulse(4'h1, 4'h0, 1, 16'hBEEF);
        rd_chk(3'd6, 16'h1234, "R10 old data transferred");
        pulse(4'h1, 4'h0, 0, 16'h0);
        rd_chk(3'd6, 16'hBEEF, "R10 new data on next strobe");

        // R2: stopping again holds the outputs
        wr(3'd0, 16'h0F0F);
        wr(3'd5, 16'h1);
        pulse(4'hF, 4'hF, 0, 16'h0);
        chk("R2 outputs held", pulse_out, 16'hBEEF);
        wr(3'd0, 16'hFFFF);
        rd_chk(3'd0, 16'h0F0F, "R2 next-data unchanged");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule